// File: doc/BRIEF.md
# Two-Register ALU with Carry Flag

This block is the execution unit of a small 8-bit processor that keeps two working registers and a single carry bit. Each cycle it may accept one already fetched operation code together with the current values of both working registers and the carry bit. One clock later it presents a registered result. That result carries a write enable and a select for the working register to update, the new register value, and a separate write enable and value for the carry bit. The surrounding core performs the write-back.

The carry bit serves more than one purpose. It receives the result of the comparisons. It acts as a zero indicator after a step up or a step down. It holds the unsigned overflow or borrow of addition and subtraction. A dedicated opcode inverts it, which lets software build not-equal and the inclusive orderings. Opcodes that belong to other units (memory moves, immediates, jumps) are accepted but produce no write of any kind.

Top module: `alu_carry_unit`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: Opcodes 0x84, 0x85 and 0x86 compare `r0_in` and `r1_in` as unsigned numbers. They test equal, R0 greater than R1, and R0 less than R1 respectively. They write 1 into carry when the test holds and 0 otherwise, and they write no register.
- R3: Opcode 0x87 writes the inverse of `c_in` into carry and writes no register.
- R4: Opcodes 0xC0/0xC1 add one to R0 or R1, and opcodes 0xC2/0xC3 subtract one from R0 or R1. Bit 0 of the opcode selects R1. Both wrap modulo 256. Carry is written with 1 exactly when the new value is 0.
- R5: Opcode 0xC4 writes R0+R1 modulo 256 into R0 and writes the unsigned carry-out into carry.
- R6: Opcode 0xC5 writes R0−R1 modulo 256 into R0 and writes 1 into carry exactly when R0 < R1 unsigned.
- R7: Opcodes 0xC6, 0xC7, 0xC8 and 0xC9 write R0 AND R1, R0 OR R1, R0 XOR R1 and R0 XNOR R1 into R0. Carry is not written.
- R8: Opcodes 0xCA/0xCB write the bitwise inverse of R0 or R1 (bit 0 selects R1) back into that register. Carry is not written.
- R9: Opcodes of the form 101s_mnnn shift the register picked by s (1 = R1) left by nnn places (0..7). With m=0 the vacated bits fill with zeros. With m=1 the bits leaving the top re-enter at the bottom. Carry is not written.
- R10: Every other opcode, and any cycle with `op_valid` low, produces no register write and no carry write.
- R11: The result for an operation accepted on one rising edge is visible on the outputs from that edge on, and `res_valid` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 8 | Operation code |
| r0_in | input | DATA_W | Current value of working register R0 |
| r1_in | input | DATA_W | Current value of working register R1 |
| c_in | input | 1 | Current carry bit |
| res_valid | output | 1 | Result of the previous cycle's operation |
| res_reg_we | output | 1 | Write the register given by `res_reg_sel` |
| res_reg_sel | output | 1 | 0 = R0, 1 = R1 |
| res_reg_data | output | DATA_W | New register value (0 when not writing) |
| res_c_we | output | 1 | Write the carry bit |
| res_c_val | output | 1 | New carry value |

## Verification
The bench builds the unit with its default `DATA_W` of 8, the only width the instruction encoding defines. At that width every boundary is cheap to reach: the wrap of 0xFF to 0x00 and of 0x00 to 0xFF, additions that overflow to exactly zero, and borrows of one. The full 256-value opcode space is also small enough to sweep, unused codes included. A second, pseudo-random pass of operands and opcodes then probes combinations that the directed cases miss.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W    = 8;
    localparam int SHAMT_W = 3;

    typedef enum logic [3:0] {
        K_NONE, K_EQ, K_GT, K_LT, K_CNOT,
        K_SHL,  K_ROL, K_INC, K_DEC, K_ADD,
        K_SUB,  K_AND, K_OR,  K_XOR, K_XNOR, K_CPL
    } kind_e;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [OP_W-1:0]    op_code,
    output kind_e              kind,
    output logic               sel,
    output logic [SHAMT_W-1:0] shamt
);

    always_comb begin
        kind  = K_NONE;
        sel   = 1'b0;
        shamt = op_code[SHAMT_W-1:0];
        casez (op_code)
            8'b1000_0100: kind = K_EQ;
            8'b1000_0101: kind = K_GT;
            8'b1000_0110: kind = K_LT;
            8'b1000_0111: kind = K_CNOT;
            8'b101?_0???: begin kind = K_SHL; sel = op_code[4]; end
            8'b101?_1???: begin kind = K_ROL; sel = op_code[4]; end
            8'b1100_000?: begin kind = K_INC; sel = op_code[0]; end
            8'b1100_001?: begin kind = K_DEC; sel = op_code[0]; end
            8'b1100_0100: kind = K_ADD;
            8'b1100_0101: kind = K_SUB;
            8'b1100_0110: kind = K_AND;
            8'b1100_0111: kind = K_OR;
            8'b1100_1000: kind = K_XOR;
            8'b1100_1001: kind = K_XNOR;
            8'b1100_101?: begin kind = K_CPL; sel = op_code[0]; end
            default:      kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]  opnd,
    input  logic [SHAMT_W-1:0] amt,
    output logic [DATA_W-1:0]  shl_out,
    output logic [DATA_W-1:0]  rol_out
);

    always_comb begin
        shl_out = opnd << amt;
        for (int i = 0; i < DATA_W; i++) begin
            rol_out[i] = opnd[(i - int'(amt) + DATA_W) % DATA_W];
        end
    end

endmodule

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  kind_e             kind,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] value,
    output logic              flag
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   diff_w;
    logic [DATA_W-1:0] step;

    always_comb begin
        sum_w  = {1'b0, a} + {1'b0, b};
        diff_w = {1'b0, a} - {1'b0, b};
        step   = (kind == K_DEC) ? (opnd - ONE) : (opnd + ONE);
        value  = '0;
        flag   = 1'b0;
        case (kind)
            K_INC, K_DEC: begin value = step; flag = (step == '0); end
            K_ADD:        begin value = sum_w[DATA_W-1:0];  flag = sum_w[DATA_W];  end
            K_SUB:        begin value = diff_w[DATA_W-1:0]; flag = diff_w[DATA_W]; end
            default:      begin value = '0; flag = 1'b0; end
        endcase
    end

endmodule

// File: rtl/alu_carry_unit.sv
module alu_carry_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    input  logic [DATA_W-1:0] r0_in,
    input  logic [DATA_W-1:0] r1_in,
    input  logic              c_in,
    output logic              res_valid,
    output logic              res_reg_we,
    output logic              res_reg_sel,
    output logic [DATA_W-1:0] res_reg_data,
    output logic              res_c_we,
    output logic              res_c_val
);

    typedef struct packed {
        logic              valid;
        logic              reg_we;
        logic              reg_sel;
        logic [DATA_W-1:0] reg_data;
        logic              c_we;
        logic              c_val;
    } res_t;

    kind_e              kind;
    logic               sel;
    logic [SHAMT_W-1:0] shamt;
    logic [DATA_W-1:0]  opnd;
    logic [DATA_W-1:0]  shl_val;
    logic [DATA_W-1:0]  rol_val;
    logic [DATA_W-1:0]  ar_val;
    logic               ar_flag;
    res_t               res_d;
    res_t               res_q;

    alu_decode u_decode (
        .op_code (op_code),
        .kind    (kind),
        .sel     (sel),
        .shamt   (shamt)
    );

    assign opnd = sel ? r1_in : r0_in;

    alu_shift #(.DATA_W(DATA_W)) u_shift (
        .opnd    (opnd),
        .amt     (shamt),
        .shl_out (shl_val),
        .rol_out (rol_val)
    );

    alu_arith #(.DATA_W(DATA_W)) u_arith (
        .kind  (kind),
        .a     (r0_in),
        .b     (r1_in),
        .opnd  (opnd),
        .value (ar_val),
        .flag  (ar_flag)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = op_valid;
        if (op_valid) begin
            case (kind)
                K_EQ:   begin res_d.c_we = 1'b1; res_d.c_val = (r0_in == r1_in); end
                K_GT:   begin res_d.c_we = 1'b1; res_d.c_val = (r0_in >  r1_in); end
                K_LT:   begin res_d.c_we = 1'b1; res_d.c_val = (r0_in <  r1_in); end
                K_CNOT: begin res_d.c_we = 1'b1; res_d.c_val = ~c_in;            end
                K_SHL, K_ROL: begin
                    res_d.reg_we   = 1'b1;
                    res_d.reg_sel  = sel;
                    res_d.reg_data = (kind == K_ROL) ? rol_val : shl_val;
                end
                K_INC, K_DEC, K_ADD, K_SUB: begin
                    res_d.reg_we   = 1'b1;
                    res_d.reg_sel  = sel;
                    res_d.reg_data = ar_val;
                    res_d.c_we     = 1'b1;
                    res_d.c_val    = ar_flag;
                end
                K_AND:  begin res_d.reg_we = 1'b1; res_d.reg_data = r0_in & r1_in;    end
                K_OR:   begin res_d.reg_we = 1'b1; res_d.reg_data = r0_in | r1_in;    end
                K_XOR:  begin res_d.reg_we = 1'b1; res_d.reg_data = r0_in ^ r1_in;    end
                K_XNOR: begin res_d.reg_we = 1'b1; res_d.reg_data = ~(r0_in ^ r1_in); end
                K_CPL: begin
                    res_d.reg_we   = 1'b1;
                    res_d.reg_sel  = sel;
                    res_d.reg_data = ~opnd;
                end
                default: res_d.valid = op_valid;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid    = res_q.valid;
    assign res_reg_we   = res_q.reg_we;
    assign res_reg_sel  = res_q.reg_sel;
    assign res_reg_data = res_q.reg_data;
    assign res_c_we     = res_q.c_we;
    assign res_c_val    = res_q.c_val;

    // R2: comparisons touch carry only
    a_r2_cmp_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_code >= 8'h84 && op_code <= 8'h86) |-> res_c_we && !res_reg_we);

    // R3: inversion of the incoming carry
    a_r3_carry_invert: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_code == 8'h87) |-> res_c_we && (res_c_val == !$past(c_in)));

    // R4: step up/down flags a zero result
    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_code[7:2] == 6'b110000) |->
            res_c_we && (res_c_val == (res_reg_data == '0)));

    // R5: sum and carry-out together
    a_r5_add_total: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_code == 8'hC4) |->
            {res_c_val, res_reg_data} == $past({1'b0, r0_in} + {1'b0, r1_in}));

    // R9: shifts leave carry alone and target the chosen register
    a_r9_shift_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_code[7:5] == 3'b101) |->
            !res_c_we && res_reg_we && (res_reg_sel == $past(op_code[4])));

    // R10 / R11: idle cycles produce nothing
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(op_valid) |-> !res_valid && !res_reg_we && !res_c_we);

endmodule

// File: tb/alu_carry_unit_tb.sv
module alu_carry_unit_tb_top;

    typedef struct {
        logic       reg_we;
        logic       reg_sel;
        logic [7:0] reg_data;
        logic       c_we;
        logic       c_val;
        int         stamp;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic [7:0] r0_in = 8'h00;
    logic [7:0] r1_in = 8'h00;
    logic       c_in = 1'b0;
    logic       res_valid, res_reg_we, res_reg_sel, res_c_we, res_c_val;
    logic [7:0] res_reg_data;

    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    exp_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    alu_carry_unit #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .r0_in(r0_in), .r1_in(r1_in), .c_in(c_in),
        .res_valid(res_valid), .res_reg_we(res_reg_we), .res_reg_sel(res_reg_sel),
        .res_reg_data(res_reg_data), .res_c_we(res_c_we), .res_c_val(res_c_val)
    );

    function automatic string req_of(logic [7:0] op);
        casez (op)
            8'b1000_01??: return (op == 8'h87) ? "R3" : "R2";
            8'b101?_????: return "R9";
            8'b1100_00??: return "R4";
            8'hC4:        return "R5";
            8'hC5:        return "R6";
            8'hC6, 8'hC7, 8'hC8, 8'hC9: return "R7";
            8'b1100_101?: return "R8";
            default:      return "R10";
        endcase
    endfunction

    function automatic exp_t model(logic [7:0] op, logic [7:0] a, logic [7:0] b, logic c);
        exp_t e;
        logic [7:0] x;
        logic [8:0] w;
        int s;
        e.reg_we = 0; e.reg_sel = 0; e.reg_data = 0; e.c_we = 0; e.c_val = 0;
        e.stamp = 0; e.req = req_of(op);
        s = int'(op[2:0]);
        casez (op)
            8'h84: begin e.c_we = 1; e.c_val = (a == b); end
            8'h85: begin e.c_we = 1; e.c_val = (a > b); end
            8'h86: begin e.c_we = 1; e.c_val = (a < b); end
            8'h87: begin e.c_we = 1; e.c_val = !c; end
            8'b101?_????: begin
                x = op[4] ? b : a;
                e.reg_we = 1; e.reg_sel = op[4];
                e.reg_data = op[3] ? ((x << s) | (x >> (8 - s))) : (x << s);
            end
            8'b1100_000?, 8'b1100_001?: begin
                x = op[0] ? b : a;
                x = op[1] ? x - 8'd1 : x + 8'd1;
                e.reg_we = 1; e.reg_sel = op[0]; e.reg_data = x;
                e.c_we = 1; e.c_val = (x == 0);
            end
            8'hC4: begin w = a + b; e.reg_we = 1; e.reg_data = w[7:0]; e.c_we = 1; e.c_val = w[8]; end
            8'hC5: begin e.reg_we = 1; e.reg_data = a - b; e.c_we = 1; e.c_val = (a < b); end
            8'hC6: begin e.reg_we = 1; e.reg_data = a & b; end
            8'hC7: begin e.reg_we = 1; e.reg_data = a | b; end
            8'hC8: begin e.reg_we = 1; e.reg_data = a ^ b; end
            8'hC9: begin e.reg_we = 1; e.reg_data = ~(a ^ b); end
            8'b1100_101?: begin e.reg_we = 1; e.reg_sel = op[0]; e.reg_data = op[0] ? ~b : ~a; end
            default: ;
        endcase
        return e;
    endfunction

    task automatic send(logic [7:0] op, logic [7:0] a, logic [7:0] b, logic c);
        exp_t e;
        @(negedge clk);
        op_valid = 1; op_code = op; r0_in = a; r1_in = b; c_in = c;
        e = model(op, a, b, c);
        e.stamp = cyc + 1;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 0; op_code = $urandom(); r0_in = $urandom(); r1_in = $urandom();
        end
    endtask

    // monitor: compares each result against the head of the queue
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && res_valid) begin
                n_checks++;
                if (q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R11: result with nothing expected (we=%0b cwe=%0b) expected none",
                             res_reg_we, res_c_we);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (cyc != e.stamp || res_reg_we !== e.reg_we || res_c_we !== e.c_we ||
                        (e.reg_we && (res_reg_sel !== e.reg_sel || res_reg_data !== e.reg_data)) ||
                        (e.c_we && res_c_val !== e.c_val)) begin
                        n_fail++;
                        $display("FAIL %s: got cyc=%0d we=%0b sel=%0b d=%02h cwe=%0b c=%0b expected cyc=%0d we=%0b sel=%0b d=%02h cwe=%0b c=%0b",
                                 e.req, cyc, res_reg_we, res_reg_sel, res_reg_data, res_c_we, res_c_val,
                                 e.stamp, e.reg_we, e.reg_sel, e.reg_data, e.c_we, e.c_val);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if ({res_valid, res_reg_we, res_reg_sel, res_reg_data, res_c_we, res_c_val} !== 13'd0) begin
            n_fail++;
            $display("FAIL R1: outputs %b expected all zero",
                     {res_valid, res_reg_we, res_reg_sel, res_reg_data, res_c_we, res_c_val});
        end
        rst_n = 1;
        // R10: valid low produces nothing
        idle(3);
        @(posedge clk); #5;
        n_checks++;
        if (res_valid !== 0 || res_reg_we !== 0 || res_c_we !== 0) begin
            n_fail++;
            $display("FAIL R10: idle valid=%0b we=%0b cwe=%0b expected 0 0 0", res_valid, res_reg_we, res_c_we);
        end
        // R2 comparisons
        send(8'h84, 8'h5A, 8'h5A, 0);
        send(8'h84, 8'h5A, 8'h5B, 1);
        send(8'h85, 8'hFF, 8'h00, 0);
        send(8'h85, 8'h00, 8'hFF, 1);
        send(8'h86, 8'h7F, 8'h80, 0);
        send(8'h86, 8'h80, 8'h80, 1);
        // R3 inversion
        send(8'h87, 8'h00, 8'h00, 0);
        send(8'h87, 8'h00, 8'h00, 1);
        // R4 step up / down, wrap and zero flag
        send(8'hC0, 8'hFF, 8'h11, 0);
        send(8'hC1, 8'h22, 8'h10, 1);
        send(8'hC2, 8'h01, 8'h33, 0);
        send(8'hC3, 8'h44, 8'h00, 1);
        // R5 add
        send(8'hC4, 8'h80, 8'h80, 0);
        send(8'hC4, 8'h03, 8'h04, 1);
        send(8'hC4, 8'hFF, 8'h01, 0);
        // R6 subtract
        send(8'hC5, 8'h05, 8'h07, 0);
        send(8'hC5, 8'h07, 8'h05, 1);
        send(8'hC5, 8'h00, 8'h01, 0);
        // R7 bitwise
        send(8'hC6, 8'hF0, 8'h3C, 1);
        send(8'hC7, 8'hF0, 8'h3C, 0);
        send(8'hC8, 8'hF0, 8'h3C, 1);
        send(8'hC9, 8'hF0, 8'h3C, 0);
        // R8 complement
        send(8'hCA, 8'hA5, 8'h0F, 0);
        send(8'hCB, 8'hA5, 8'h0F, 1);
        // R9 shifts
        send(8'hA3, 8'h81, 8'h00, 0);
        send(8'hBF, 8'h00, 8'h81, 1);
        send(8'hA8, 8'h96, 8'h00, 0);
        send(8'hB7, 8'h00, 8'hFF, 0);
        // R10 codes of other units
        send(8'h00, 8'h12, 8'h34, 1);
        send(8'h93, 8'h12, 8'h34, 0);
        send(8'h83, 8'h12, 8'h34, 1);
        send(8'hCC, 8'h12, 8'h34, 0);
        send(8'hFF, 8'h12, 8'h34, 1);
        // R11: gaps between operations
        idle(2);
        send(8'hC4, 8'h10, 8'h20, 0);
        idle(1);
        // full opcode sweep
        for (int op = 0; op < 256; op++) begin
            send(8'(op), 8'($urandom()), 8'($urandom()), 1'($urandom()));
        end
        // random mix
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 3) == 0) idle(1);
            send(8'($urandom()), 8'($urandom()), 8'($urandom()), 1'($urandom()));
        end
        idle(3);
        @(posedge clk); #6;
        n_checks++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R11: %0d results missing, expected 0", q.size());
        end
        finish_run();
    end

endmodule